// File: doc/BRIEF.md
# SD host interrupt status logic

This block keeps the normal interrupt status flags of an SD/SDIO host and drives the single interrupt line toward the host processor. It watches the debounced card-present signal for insertion and removal. It follows the card's own interrupt request on the data line, latches the command-complete event from a CE-ATA device, and times the start of a read-wait sequence after a block read.

Software reads a four-bit status word and clears flags by writing ones to them. Two per-bit enable registers decide which events may set a flag (status enable) and which flags reach the interrupt line (signal enable). The card-detect and card-interrupt inputs are asynchronous. Each passes through a two-flop synchronizer before any edge or level is acted on. The `sd_tick_i` input marks one SD clock period per pulse in the register clock domain.

Status bit map: bit 0 insertion, bit 1 removal, bit 2 card interrupt, bit 3 CE-ATA command complete.

Top module: `sd_irq_status`

## Requirements
- R1: A 0-to-1 change of `card_present_i` sets status bit 0. The bit becomes visible after the third rising clock edge following the input change, and it holds until software clears it.
- R2: A 1-to-0 change of `card_present_i` sets status bit 1, with the same latency as R1, and the bit holds until software clears it.
- R3: A status write with a 1 in bit 0, 1 or 3 clears that event after one edge. A write of 0 to any bit leaves that bit unchanged.
- R4: When a set event and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R5: Status bit 2 ignores clearing writes and follows the synchronized card interrupt level. It is forced low, and stops driving the interrupt line, whenever bit 2 of either enable register is 0. Sampling resumes once both enable bits are 1 again.
- R6: With `bus_4bit_i`=0, bit 2 tracks the synchronized card interrupt level on every cycle. With `bus_4bit_i`=1, bit 2 updates only in cycles where `irq_window_i`=1 and holds its value otherwise.
- R7: Status bit 3 has inverted polarity. It reads 0 while a command-complete event is latched and 1 while none is latched. It reads 0 whenever status-enable bit 3 is 0, so its value after reset is 0.
- R8: An event whose status-enable bit is 0 sets nothing, and a later enable does not set the flag retroactively.
- R9: `irq_o` is 1 exactly when some latched event (insertion, removal, card interrupt, or command complete) has its signal-enable bit set.
- R10: After a `rd_block_end_i` pulse, `read_wait_start_o` pulses high for one cycle, right after the edge on which the fourth following `sd_tick_i` is sampled.
- R11: After reset, the status word, both enable registers, `irq_o` and `read_wait_start_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| card_present_i | input | 1 | Debounced card-present level, asynchronous |
| card_irq_i | input | 1 | Card interrupt request level, asynchronous, active high |
| bus_4bit_i | input | 1 | 1 selects 4-bit bus mode, 0 selects 1-bit mode |
| irq_window_i | input | 1 | High during the interrupt period of the 4-bit bus cycle |
| cmd_done_i | input | 1 | One-cycle CE-ATA command-complete event |
| rd_block_end_i | input | 1 | One-cycle pulse at the end of a block read |
| sd_tick_i | input | 1 | One pulse per SD clock period |
| stat_we_i | input | 1 | Status write strobe (write one to clear) |
| stat_en_we_i | input | 1 | Status-enable register write strobe |
| sig_en_we_i | input | 1 | Signal-enable register write strobe |
| wdata_i | input | 4 | Write data for all three registers |
| status_o | output | 4 | Status word |
| stat_en_o | output | 4 | Status-enable register readback |
| sig_en_o | output | 4 | Signal-enable register readback |
| irq_o | output | 1 | Combined interrupt line to the host |
| read_wait_start_o | output | 1 | One-cycle read-wait start pulse |

## Verification
The latencies differ by source. Card-detect and card-interrupt changes pass two synchronizer flops and one status flop, so they show after the third edge. Command-complete events and status writes show after one edge. A signal-enable write reaches bit 2 one edge later than the register itself.

Every check samples on the falling edge after the counted number of rising edges. Where timing matters, a check also samples one edge early, which confirms the result is neither premature nor late. The read-wait test checks the output low after each of the first three SD ticks, high right after the fourth, and low again one cycle later.

// File: rtl/sd_irq_status.sv
module sd_irq_status #(
  parameter int SYNC_STAGES = 2,
  parameter int RW_DELAY    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       card_present_i,
  input  logic       card_irq_i,
  input  logic       bus_4bit_i,
  input  logic       irq_window_i,
  input  logic       cmd_done_i,
  input  logic       rd_block_end_i,
  input  logic       sd_tick_i,
  input  logic       stat_we_i,
  input  logic       stat_en_we_i,
  input  logic       sig_en_we_i,
  input  logic [3:0] wdata_i,
  output logic [3:0] status_o,
  output logic [3:0] stat_en_o,
  output logic [3:0] sig_en_o,
  output logic       irq_o,
  output logic       read_wait_start_o
);

  localparam int CW = $clog2(RW_DELAY + 1);

  logic [SYNC_STAGES-1:0] pres_sync, cirq_sync;
  logic            pres_d;
  logic [3:0]      sten_q, sgen_q;
  logic            st_ins, st_rem, st_card, ccs_hit;
  logic [CW-1:0]   rw_cnt;
  logic            rw_q;

  wire pres      = pres_sync[SYNC_STAGES-1];
  wire cirq      = cirq_sync[SYNC_STAGES-1];
  wire [3:0] clr = stat_we_i ? wdata_i : 4'b0000;
  wire ins_ev    = pres & ~pres_d & sten_q[0];
  wire rem_ev    = ~pres & pres_d & sten_q[1];
  wire ccs_ev    = cmd_done_i & sten_q[3];
  wire card_live = sten_q[2] & sgen_q[2];
  wire card_take = ~bus_4bit_i | irq_window_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pres_sync <= '0;
      cirq_sync <= '0;
      pres_d    <= 1'b0;
    end else begin
      pres_sync <= {pres_sync[SYNC_STAGES-2:0], card_present_i};
      cirq_sync <= {cirq_sync[SYNC_STAGES-2:0], card_irq_i};
      pres_d    <= pres;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sten_q <= '0;
      sgen_q <= '0;
    end else begin
      if (stat_en_we_i) sten_q <= wdata_i;
      if (sig_en_we_i)  sgen_q <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_ins  <= 1'b0;
      st_rem  <= 1'b0;
      ccs_hit <= 1'b0;
      st_card <= 1'b0;
    end else begin
      st_ins  <= ins_ev | (st_ins  & ~clr[0]);
      st_rem  <= rem_ev | (st_rem  & ~clr[1]);
      ccs_hit <= ccs_ev | (ccs_hit & ~clr[3]);
      if (!card_live)     st_card <= 1'b0;
      else if (card_take) st_card <= cirq;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rw_cnt <= '0;
      rw_q   <= 1'b0;
    end else begin
      rw_q <= sd_tick_i & (rw_cnt == CW'(1)) & ~rd_block_end_i;
      if (rd_block_end_i)                 rw_cnt <= CW'(RW_DELAY);
      else if (sd_tick_i && rw_cnt != '0) rw_cnt <= rw_cnt - CW'(1);
    end
  end

  assign status_o          = {sten_q[3] & ~ccs_hit, st_card, st_rem, st_ins};
  assign stat_en_o         = sten_q;
  assign sig_en_o          = sgen_q;
  assign irq_o             = |({ccs_hit, st_card, st_rem, st_ins} & sgen_q);
  assign read_wait_start_o = rw_q;

  assert_ins_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ins_ev |=> status_o[0]);
  assert_rem_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rem_ev |=> status_o[1]);
  assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_we_i && wdata_i[0] && !ins_ev) |=> !status_o[0]);
  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ccs_ev && stat_we_i && wdata_i[3]) |=> irq_o || !sgen_q[3]);
  assert_card_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sgen_q[2] |=> !status_o[2]);
  assert_card_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_4bit_i && !irq_window_i && card_live) |=> $stable(status_o[2]));
  assert_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sten_q[0] && !status_o[0]) |=> !status_o[0]);
  assert_rw_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    read_wait_start_o |=> !read_wait_start_o);

endmodule

// File: tb/sim_sd_irq_status.sv
`timescale 1ns/1ps
module sim_sd_irq_status;
  logic clk = 0, rst_n = 0;
  logic card_present = 0, card_irq = 0, bus_4bit = 0, irq_window = 0;
  logic cmd_done = 0, rd_end = 0, sd_tick = 0;
  logic st_we = 0, sten_we = 0, sgen_we = 0;
  logic [3:0] wdata = 0;
  logic [3:0] status, sten, sgen;
  logic irq, rw_start;
  int nchk = 0, nfail = 0;

  always #4 clk = ~clk;

  sd_irq_status u0 (
    .clk(clk), .rst_n(rst_n), .card_present_i(card_present), .card_irq_i(card_irq),
    .bus_4bit_i(bus_4bit), .irq_window_i(irq_window), .cmd_done_i(cmd_done),
    .rd_block_end_i(rd_end), .sd_tick_i(sd_tick), .stat_we_i(st_we),
    .stat_en_we_i(sten_we), .sig_en_we_i(sgen_we), .wdata_i(wdata),
    .status_o(status), .stat_en_o(sten), .sig_en_o(sgen), .irq_o(irq),
    .read_wait_start_o(rw_start));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_stat(logic [3:0] v);
    st_we = 1; wdata = v; tick(1); st_we = 0;
  endtask
  task automatic wr_sten(logic [3:0] v);
    sten_we = 1; wdata = v; tick(1); sten_we = 0;
  endtask
  task automatic wr_sgen(logic [3:0] v);
    sgen_we = 1; wdata = v; tick(1); sgen_we = 0;
  endtask

  task automatic t_reset;
    chk("R11 status", status, 4'h0);
    chk("R11 enables", {sten, sgen}, 8'h00);
    chk("R11 irq", irq, 1'b0);
    chk("R11 read wait", rw_start, 1'b0);
  endtask

  task automatic t_insert;
    wr_sten(4'hF); wr_sgen(4'hF);
    chk("R7 idle reads 1", status, 4'b1000);
    card_present = 1; tick(2);
    chk("R1 not yet", status[0], 1'b0);
    tick(1);
    chk("R1 inserted", status, 4'b1001);
    chk("R9 irq", irq, 1'b1);
  endtask

  task automatic t_clear;
    wr_stat(4'h0);
    chk("R3 write 0 no effect", status, 4'b1001);
    wr_stat(4'h1);
    chk("R3 cleared", status, 4'b1000);
    chk("R9 irq low", irq, 1'b0);
  endtask

  task automatic t_remove;
    card_present = 0; tick(3);
    chk("R2 removed", status, 4'b1010);
    wr_stat(4'h2);
    chk("R3 removal cleared", status, 4'b1000);
  endtask

  task automatic t_ccs;
    cmd_done = 1; st_we = 1; wdata = 4'h8; tick(1); cmd_done = 0; st_we = 0;
    chk("R4 set wins", status, 4'b0000);
    chk("R7 R9 irq on event", irq, 1'b1);
    wr_stat(4'h8);
    chk("R7 cleared reads 1", status, 4'b1000);
    chk("R3 irq low", irq, 1'b0);
  endtask

  task automatic t_gate;
    wr_sten(4'b1110);
    card_present = 1; tick(3);
    chk("R8 masked insert", status, 4'b1000);
    chk("R8 irq", irq, 1'b0);
    wr_sten(4'hF); tick(2);
    chk("R8 no late set", status, 4'b1000);
  endtask

  task automatic t_card_1bit;
    bus_4bit = 0; card_irq = 1; tick(3);
    chk("R6 1-bit follows", status[2], 1'b1);
    chk("R9 card irq", irq, 1'b1);
    wr_stat(4'h4);
    chk("R5 W1C ignored", status[2], 1'b1);
    wr_sgen(4'b1011); tick(1);
    chk("R5 drop on sig enable", status[2], 1'b0);
    chk("R5 irq stopped", irq, 1'b0);
    wr_sgen(4'hF); tick(1);
    chk("R5 resample", status[2], 1'b1);
    card_irq = 0; tick(3);
    chk("R5 follows source low", status[2], 1'b0);
  endtask

  task automatic t_card_4bit;
    bus_4bit = 1; irq_window = 0; card_irq = 1; tick(6);
    chk("R6 no window hold 0", status[2], 1'b0);
    irq_window = 1; tick(1); irq_window = 0;
    chk("R6 window sample", status[2], 1'b1);
    card_irq = 0; tick(5);
    chk("R6 hold 1", status[2], 1'b1);
    irq_window = 1; tick(1); irq_window = 0;
    chk("R6 window sample low", status[2], 1'b0);
    bus_4bit = 0;
  endtask

  task automatic t_read_wait;
    rd_end = 1; tick(1); rd_end = 0;
    for (int i = 1; i <= 4; i++) begin
      tick(2);
      chk("R10 not early", rw_start, 1'b0);
      sd_tick = 1; tick(1); sd_tick = 0;
    end
    chk("R10 start pulse", rw_start, 1'b1);
    tick(1);
    chk("R10 single pulse", rw_start, 1'b0);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  initial begin
    #800000;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    t_reset();
    t_insert();
    t_clear();
    t_remove();
    t_ccs();
    t_gate();
    t_card_1bit();
    t_card_4bit();
    t_read_wait();
    summary();
    $finish;
  end
endmodule